// File: doc/BRIEF.md
# Threshold FIFO with DMA Requests

This block is a 32-entry, 16-bit data queue between a host-side register port and a card-side data engine. In the write direction the host fills the queue through a data register and the card engine drains it. In the read direction the card engine fills the queue and the host drains it through the same data register. Each host read of that register removes the oldest word. Each host write of it appends a word.

Two programmable levels watch the fill count. An upper level serves the read direction and a lower level serves the write direction. Each level crossing does one of two things, depending on the DMA enable for its direction. With the enable set, it drives a level-based DMA request line. With the enable clear, it sets a status flag for software to poll. A transfer-active input and a direction input from the card engine decide which level applies. Clearing the enable bit in the control register empties the queue and wipes the status.

Top module: `thresh_fifo_dma`

## Requirements
- R1: The buffer configuration register (address 1) holds the receive DMA enable in bit 15, the upper level in bits 12:8, the transmit DMA enable in bit 7 and the lower level in bits 4:0. Its other bits read as zero. After reset it reads 0x1F00.
- R2: When `xfer_dir` is 1 (read direction), the fill count is above the upper level and receive DMA is enabled, `dma_rx_req` is 1. It is never 1 while `xfer_dir` is 0.
- R3: When `xfer_dir` is 1, the fill count is above the upper level and receive DMA is disabled, status bit 10 (status register, address 3) is 1 and `dma_rx_req` is 0.
- R4: When `xfer_dir` is 0 (write direction), the fill count is below the lower level and transmit DMA is enabled, `dma_tx_req` is 1.
- R5: When `xfer_dir` is 0, the fill count is below the lower level and transmit DMA is disabled, status bit 11 is 1 and `dma_tx_req` is 0.
- R6: When a direction's condition does not hold, its request and its status bit are 0. When `xfer_active` is 0 and the queue is empty, both status bits and both requests are 0. The two requests are never 1 together.
- R7: A configuration write that sets a DMA enable clears that direction's status bit in the same cycle the new configuration takes effect.
- R8: A host write to the data register (address 0) while the queue holds 32 words is dropped. The fill count stays 32 and the stored contents are unchanged.
- R9: A host read of the data register while the queue is empty does not pop, and the fill count stays 0.
- R10: Words leave in the order they entered. A host data-register write takes priority over `card_push` in the same cycle, and a host data-register read takes priority over `card_pop`. One push and one pop may occur together.
- R11: A write to the control register (address 2) with bit 0 clear empties the queue and clears the status register. Bit 0 is the controller enable and reads back at bit 0. It is 0 after reset.
- R12: The requests and the status bits are registered. After each clock edge they reflect the fill count and configuration produced by that edge, together with the `xfer_active` and `xfer_dir` values sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 2 | Register select: 0 data, 1 buffer config, 2 control, 3 status |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe (pops on data register) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for the selected register |
| xfer_active | input | 1 | A data transfer is in progress |
| xfer_dir | input | 1 | 1 = read direction (card to host), 0 = write direction |
| card_push | input | 1 | Card engine appends `card_wdata` |
| card_wdata | input | 16 | Word from the card engine |
| card_pop | input | 1 | Card engine removes the oldest word |
| card_rdata | output | 16 | Oldest word in the queue |
| fill_level | output | 6 | Current fill count |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
The bench builds the block with its default 32-word depth and 16-bit width. At that depth the register fields span the full range of both levels, including an upper level of 31 that only a completely full queue exceeds. A few hundred cycles then reach the full-queue drop and the empty-queue peek many times. A random phase toggles direction, activity and DMA enables while both sides push and pop. This drives every level against fill counts on both sides of it, and it mixes flushes with traffic on the same edge.

// File: rtl/tfd_pkg.sv
package tfd_pkg;
    localparam int LVL_W = 5;
    localparam int REG_W = 16;

    typedef enum logic [1:0] {
        ADDR_DATA   = 2'd0,
        ADDR_BUFCFG = 2'd1,
        ADDR_CTRL   = 2'd2,
        ADDR_STAT   = 2'd3
    } addr_e;

    localparam int CFG_RXEN_BIT = 15;
    localparam int CFG_UP_LSB   = 8;
    localparam int CFG_TXEN_BIT = 7;
    localparam int CFG_LO_LSB   = 0;
    localparam int STAT_UP_BIT  = 10;
    localparam int STAT_LO_BIT  = 11;

    typedef struct packed {
        logic             rx_en;
        logic [LVL_W-1:0] up_lvl;
        logic             tx_en;
        logic [LVL_W-1:0] lo_lvl;
    } bufcfg_t;
endpackage

// File: rtl/tfd_store.sv
module tfd_store #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    input  logic             flush,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_next
);
    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } ptr_t;

    ptr_t st_d, st_q;
    logic [WIDTH-1:0] mem [DEPTH];
    logic push_ok, pop_ok, wr_en;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        push_ok = push && (st_q.cnt != CNT_W'(DEPTH));
        pop_ok  = pop && (st_q.cnt != '0);
        wr_en   = push_ok && !flush;
        if (flush) begin
            st_d.wr  = st_q.rd;
            st_d.cnt = '0;
        end else begin
            if (push_ok) st_d.wr = bump(st_q.wr);
            if (pop_ok)  st_d.rd = bump(st_q.rd);
            if (push_ok && !pop_ok)      st_d.cnt = st_q.cnt + 1'b1;
            else if (pop_ok && !push_ok) st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[st_q.wr] <= push_data;
    end

    assign head     = mem[st_q.rd];
    assign cnt      = st_q.cnt;
    assign cnt_next = st_d.cnt;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH)); // R8
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_W'(DEPTH) && push && !pop && !flush) |=> (st_q.cnt == CNT_W'(DEPTH))); // R8
    AST_EMPTY_PEEK: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0 && pop && !push && !flush) |=> (st_q.cnt == '0)); // R9
endmodule

// File: rtl/tfd_level.sv
module tfd_level #(
    parameter int CNT_W = 6,
    parameter int LVL_W = 5
) (
    input  logic             active,
    input  logic             dir_rd,
    input  logic [CNT_W-1:0] cnt,
    input  logic [LVL_W-1:0] up_lvl,
    input  logic [LVL_W-1:0] lo_lvl,
    input  logic             rx_en,
    input  logic             tx_en,
    output logic             rx_req,
    output logic             tx_req,
    output logic             up_flag,
    output logic             lo_flag
);
    logic idle, rx_hit, tx_hit;

    always_comb begin
        idle    = !active && (cnt == '0);
        rx_hit  = !idle && dir_rd && (cnt > CNT_W'(up_lvl));
        tx_hit  = !idle && !dir_rd && (cnt < CNT_W'(lo_lvl));
        rx_req  = rx_hit && rx_en;
        up_flag = rx_hit && !rx_en;
        tx_req  = tx_hit && tx_en;
        lo_flag = tx_hit && !tx_en;
    end
endmodule

// File: rtl/thresh_fifo_dma.sv
module thresh_fifo_dma #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       host_addr,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [15:0]      host_wdata,
    output logic [15:0]      host_rdata,
    input  logic             xfer_active,
    input  logic             xfer_dir,
    input  logic             card_push,
    input  logic [WIDTH-1:0] card_wdata,
    input  logic             card_pop,
    output logic [WIDTH-1:0] card_rdata,
    output logic [CNT_W-1:0] fill_level,
    output logic             dma_rx_req,
    output logic             dma_tx_req
);
    import tfd_pkg::*;

    typedef struct packed {
        logic    en;
        bufcfg_t cfg;
        logic    st_up;
        logic    st_lo;
        logic    rx_req;
        logic    tx_req;
    } regs_t;

    regs_t r_d, r_q;

    logic             data_wr, data_rd, flush;
    logic             push, pop;
    logic [WIDTH-1:0] push_data, head;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             ev_rx, ev_tx, ev_up, ev_lo;
    logic             unused_wbits;

    assign unused_wbits = ^{host_wdata[14:13], host_wdata[6:5], host_wdata[15:1]};

    always_comb begin
        data_wr   = host_wr && (host_addr == ADDR_DATA);
        data_rd   = host_rd && (host_addr == ADDR_DATA);
        flush     = host_wr && (host_addr == ADDR_CTRL) && !host_wdata[0];
        push      = data_wr || card_push;
        push_data = data_wr ? WIDTH'(host_wdata) : card_wdata;
        pop       = data_rd || card_pop;
    end

    tfd_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .flush     (flush),
        .head      (head),
        .cnt       (cnt_q),
        .cnt_next  (cnt_d)
    );

    tfd_level #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_level (
        .active  (xfer_active),
        .dir_rd  (xfer_dir),
        .cnt     (cnt_d),
        .up_lvl  (r_d.cfg.up_lvl),
        .lo_lvl  (r_d.cfg.lo_lvl),
        .rx_en   (r_d.cfg.rx_en),
        .tx_en   (r_d.cfg.tx_en),
        .rx_req  (ev_rx),
        .tx_req  (ev_tx),
        .up_flag (ev_up),
        .lo_flag (ev_lo)
    );

    // configuration and control first, then the level evaluation on the new values
    always_comb begin
        r_d = r_q;
        if (host_wr && host_addr == ADDR_BUFCFG) begin
            r_d.cfg.rx_en  = host_wdata[CFG_RXEN_BIT];
            r_d.cfg.up_lvl = host_wdata[CFG_UP_LSB +: LVL_W];
            r_d.cfg.tx_en  = host_wdata[CFG_TXEN_BIT];
            r_d.cfg.lo_lvl = host_wdata[CFG_LO_LSB +: LVL_W];
        end
        if (host_wr && host_addr == ADDR_CTRL) r_d.en = host_wdata[0];
        if (flush) begin
            r_d.st_up  = 1'b0;
            r_d.st_lo  = 1'b0;
            r_d.rx_req = 1'b0;
            r_d.tx_req = 1'b0;
        end else begin
            r_d.st_up  = ev_up;
            r_d.st_lo  = ev_lo;
            r_d.rx_req = ev_rx;
            r_d.tx_req = ev_tx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q            <= '0;
            r_q.cfg.up_lvl <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        host_rdata = '0;
        unique case (host_addr)
            ADDR_DATA:   host_rdata = 16'(head);
            ADDR_BUFCFG: begin
                host_rdata[CFG_RXEN_BIT]             = r_q.cfg.rx_en;
                host_rdata[CFG_UP_LSB +: LVL_W]      = r_q.cfg.up_lvl;
                host_rdata[CFG_TXEN_BIT]             = r_q.cfg.tx_en;
                host_rdata[CFG_LO_LSB +: LVL_W]      = r_q.cfg.lo_lvl;
            end
            ADDR_CTRL:   host_rdata[0] = r_q.en;
            ADDR_STAT:   begin
                host_rdata[STAT_UP_BIT] = r_q.st_up;
                host_rdata[STAT_LO_BIT] = r_q.st_lo;
            end
            default:     host_rdata = '0;
        endcase
    end

    assign card_rdata = head;
    assign fill_level = cnt_q;
    assign dma_rx_req = r_q.rx_req;
    assign dma_tx_req = r_q.tx_req;

    AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_q.rx_req && r_q.tx_req)); // R6
    AST_RX_READ_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr == 1'b0 && r_d.rx_req) |-> xfer_dir); // R2
    AST_RXEN_NO_UPFLAG: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cfg.rx_en |-> !r_q.st_up); // R7
    AST_TXEN_NO_LOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cfg.tx_en |-> !r_q.st_lo); // R7
    AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == ADDR_CTRL && !host_wdata[0]) |=>
        (cnt_q == '0 && !r_q.st_up && !r_q.st_lo)); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_active && cnt_d == '0) |=> (!r_q.st_up && !r_q.st_lo && !r_q.rx_req && !r_q.tx_req)); // R6
endmodule

// File: tb/tb_thresh_fifo_dma.sv
module tb_thresh_fifo_dma;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        xfer_active = 1'b0;
    logic        xfer_dir = 1'b0;
    logic        card_push = 1'b0;
    logic [15:0] card_wdata = '0;
    logic        card_pop = 1'b0;
    logic [15:0] card_rdata;
    logic [5:0]  fill_level;
    logic        dma_rx_req, dma_tx_req;

    thresh_fifo_dma dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .xfer_active(xfer_active), .xfer_dir(xfer_dir), .card_push(card_push),
        .card_wdata(card_wdata), .card_pop(card_pop), .card_rdata(card_rdata),
        .fill_level(fill_level), .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state
    int q[$];
    bit m_en = 0, m_rxen = 0, m_txen = 0;
    int m_up = 31, m_lo = 0;
    bit e_up = 0, e_lo = 0, e_rx = 0, e_tx = 0;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int cfg_word();
        return (int'(m_rxen) << 15) | (m_up << 8) | (int'(m_txen) << 7) | m_lo;
    endfunction

    task automatic precheck();
        if (host_rd) begin
            case (host_addr)
                2'd0: if (q.size() > 0) chk("R10 host data order", host_rdata, q[0]);
                2'd1: chk("R1 bufcfg readback", host_rdata, cfg_word());
                2'd2: chk("R11 ctrl readback", host_rdata, int'(m_en));
                default: chk("R3 R5 status readback", host_rdata, (int'(e_lo) << 11) | (int'(e_up) << 10));
            endcase
        end
        if (card_pop && q.size() > 0) chk("R10 card data order", card_rdata, q[0]);
    endtask

    task automatic model_update();
        bit hw, hr, fl, dpush, dpop;
        int n0, pd, n;
        bit rxc, txc;
        hw = host_wr && host_addr == 2'd0;
        hr = host_rd && host_addr == 2'd0;
        fl = host_wr && host_addr == 2'd2 && !host_wdata[0];
        n0 = q.size();
        dpush = (hw || card_push) && n0 < DEPTH;
        dpop  = (hr || card_pop) && n0 > 0;
        pd = hw ? int'(host_wdata) : int'(card_wdata);
        if (host_wr && host_addr == 2'd2) m_en = host_wdata[0];
        if (host_wr && host_addr == 2'd1) begin
            m_rxen = host_wdata[15];
            m_up   = int'(host_wdata[12:8]);
            m_txen = host_wdata[7];
            m_lo   = int'(host_wdata[4:0]);
        end
        if (fl) q.delete();
        else begin
            if (dpop) void'(q.pop_front());
            if (dpush) q.push_back(pd);
        end
        n = q.size();
        if (fl || (!xfer_active && n == 0)) begin
            e_up = 0; e_lo = 0; e_rx = 0; e_tx = 0;
        end else begin
            rxc = xfer_dir && n > m_up;
            txc = !xfer_dir && n < m_lo;
            e_rx = rxc && m_rxen;
            e_up = rxc && !m_rxen;
            e_tx = txc && m_txen;
            e_lo = txc && !m_txen;
        end
    endtask

    task automatic postcheck();
        chk("R10 fill level", fill_level, q.size());
        chk("R2 R12 rx request", dma_rx_req, e_rx);
        chk("R4 R12 tx request", dma_tx_req, e_tx);
    endtask

    task automatic step();
        #1;
        precheck();
        @(posedge clk);
        model_update();
        @(negedge clk);
        postcheck();
        host_wr = 0; host_rd = 0; card_push = 0; card_pop = 0;
    endtask

    task automatic hwrite(int a, int d);
        host_addr = 2'(a); host_wdata = 16'(d); host_wr = 1; step();
    endtask

    task automatic hread(int a);
        host_addr = 2'(a); host_rd = 1; step();
    endtask

    task automatic cpush(int d);
        card_wdata = 16'(d); card_push = 1; step();
    endtask

    task automatic cpop();
        card_pop = 1; step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // reset state
        chk("R1 reset fill", fill_level, 0);
        chk("R6 reset rx request", dma_rx_req, 0);
        chk("R6 reset tx request", dma_tx_req, 0);
        hread(1);
        chk("R1 reset bufcfg 0x1F00", host_rdata, 16'h1F00);
        hread(2);
        hread(3);

        hwrite(2, 1);
        // write direction, lower level 4, no DMA
        xfer_active = 1; xfer_dir = 0;
        hwrite(1, 16'h1F04);
        hread(3);
        chk("R5 lower flag set", host_rdata, 16'h0800);
        for (int i = 0; i < 5; i++) hwrite(0, 16'h1000 + i);
        hread(3);
        chk("R6 lower flag cleared at level", host_rdata, 16'h0000);
        hwrite(1, 16'h1F84);
        cpop(); cpop();
        chk("R4 tx request below level", dma_tx_req, 1);
        hwrite(1, 16'h1F04);
        hread(3);
        chk("R5 flag without tx dma", host_rdata, 16'h0800);
        hwrite(1, 16'h1F84);
        hread(3);
        chk("R7 tx enable clears flag", host_rdata, 16'h0000);
        // fill to full and try one more
        while (q.size() < DEPTH) hwrite(0, 16'h2000 + q.size());
        hwrite(0, 16'hDEAD);
        chk("R8 full write dropped", fill_level, DEPTH);
        while (q.size() > 0) cpop();

        // read direction, upper level 3
        xfer_dir = 1;
        hwrite(1, 16'h0300);
        for (int i = 0; i < 5; i++) cpush(16'h3000 + i);
        hread(3);
        chk("R3 upper flag set", host_rdata, 16'h0400);
        hwrite(1, 16'h8300);
        chk("R2 rx request above level", dma_rx_req, 1);
        hread(3);
        chk("R7 rx enable clears flag", host_rdata, 16'h0000);
        hread(0); hread(0);
        chk("R6 rx request drops at level", dma_rx_req, 0);
        // host write beats card push
        host_addr = 0; host_wdata = 16'h4444; host_wr = 1; card_wdata = 16'h5555; card_push = 1; step();
        chk("R10 host priority fill", fill_level, 4);
        while (q.size() > 0) hread(0);
        hread(0);
        chk("R9 empty read no pop", fill_level, 0);
        xfer_active = 0;
        step();
        hread(3);
        chk("R6 idle empty status", host_rdata, 16'h0000);
        // flush via enable clear
        xfer_active = 1;
        hwrite(1, 16'h0000);
        cpush(16'h6001); cpush(16'h6002);
        hread(3);
        chk("R3 upper flag before flush", host_rdata, 16'h0400);
        hwrite(2, 0);
        chk("R11 flush empties", fill_level, 0);
        hread(3);
        chk("R11 flush clears status", host_rdata, 16'h0000);
        hwrite(2, 1);

        // random traffic
        for (int c = 0; c < 4000; c++) begin
            int op;
            op = $urandom_range(0, 99);
            if ($urandom_range(0, 49) == 0) xfer_active = $urandom_range(0, 1);
            if ($urandom_range(0, 49) == 0) xfer_dir = $urandom_range(0, 1);
            if (op < 30) begin
                host_addr = 0; host_wr = 1; host_wdata = 16'($urandom);
            end else if (op < 55) begin
                host_addr = 0; host_rd = 1;
            end else if (op < 60) begin
                host_addr = 1; host_wr = 1; host_wdata = 16'($urandom);
            end else if (op < 61) begin
                host_addr = 2; host_wr = 1; host_wdata = 16'($urandom_range(0, 1));
            end else if (op < 75) begin
                host_addr = 2'($urandom_range(1, 3)); host_rd = 1;
            end
            card_push = $urandom_range(0, 2) == 0;
            card_wdata = 16'($urandom);
            card_pop = $urandom_range(0, 2) == 0;
            step();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule